// File: doc/BRIEF.md
# Nonce Search Controller

This block sits between a bus master and a hash pipeline used for proof-of-work search. Software sets a difficulty target and a control word through a Wishbone slave register window. A counter on the miner clock then proposes one candidate nonce per cycle to the pipeline, and checks each hash that comes back with its nonce. The first acceptable hash stops the search. The counter freezes on the winning nonce, and that nonce is handed to the bus side, where software reads it as two 32-bit words.

The bus registers run on the Wishbone clock. The counter, the comparator and the working copy of the configuration run on a separate miner clock. Configuration moves into the miner domain through a toggle that is synchronized there, and the miner loads the stable bus registers when that toggle changes. Status levels come back through two-flop synchronizers. The winning nonce crosses with a toggle request and a toggle acknowledge, so the two halves software reads always belong together. Two modes are offered. In normal mode a hash is accepted when it is at or below the target. In test mode the hash must equal the target exactly.

Top module: `mine_ctrl`

## Requirements
- R1: After reset every readable word returns 0 and `cand_nonce` is 0.
- R2: Word offsets from the base address 0x30000000 are: 0x0 nonce low half, 0x4 nonce high half, 0x8 status, 0xC control, and from 0x10 upward the target words, least significant word first. Control keeps only bits 31:16 and 2:0, and its other bits read as 0. Target words read back what was written. Each byte lane is written only when its select bit is set. Every access is acknowledged with a single-cycle pulse.
- R3: Writes to the nonce and status words, and all accesses outside the block's address window, are acknowledged and change nothing. Reads outside the window return 0.
- R4: With control bit 0 (RUN) set, no halt and no solution held, `cand_nonce` advances by one on every miner clock, and status bit 1 (RUNNING) reads 1.
- R5: In normal mode, a returned hash that is less than or equal to the target (unsigned) freezes `cand_nonce` at the returned nonce. Status bit 0 (FOUND) then reads 1, and the two nonce words return that nonce and stay unchanged.
- R6: In normal mode, a returned hash that is greater than the target has no effect on the counter, FOUND or the nonce words.
- R7: With control bit 1 (TEST) set, only a hash equal to the target is accepted. Status bit 2 (TESTING) reads 1 when TEST is set and the last returned hash equalled the target.
- R8: With control bit 2 (HALT) set, the counter holds its value, returned hashes are ignored, and RUNNING reads 0.
- R9: Writing control with RUN clear drops FOUND, returns the counter to 0, and rearms the search for the next RUN.
- R10: The miner-domain output `pad_last` follows control bits 23:16, and `pad_first` follows bits 31:24.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| wb_clk | input | 1 | Bus clock |
| wb_rst | input | 1 | Bus reset, active high |
| wbs_cyc | input | 1 | Bus cycle |
| wbs_stb | input | 1 | Bus strobe |
| wbs_we | input | 1 | Write enable |
| wbs_sel | input | 4 | Byte lane selects |
| wbs_adr | input | 32 | Byte address |
| wbs_dat_i | input | 32 | Write data |
| wbs_ack | output | 1 | Access acknowledge |
| wbs_dat_o | output | 32 | Read data |
| m_clk | input | 1 | Miner clock |
| m_rst | input | 1 | Miner reset, active high |
| cand_nonce | output | 64 | Candidate nonce to the pipeline |
| hash_vld | input | 1 | Returned hash is valid |
| hash_nonce | input | 64 | Nonce that produced the returned hash |
| hash_val | input | HASH_W | Returned hash |
| pad_first | output | 8 | First pad byte for the pipeline |
| pad_last | output | 8 | Last pad byte for the pipeline |

## Verification
The comparator is driven with hashes one above the target, equal to the target, and below it. Normal mode must accept the equal and lower values and refuse the higher one. Test mode must refuse the lower value and accept only the equal one, which separates a threshold compare from an exact compare. The same accepted hash is then presented under HALT, which shows whether halt really gates capture and not just the counter. Comparing the frozen counter with the nonce words read over the bus shows that the handshake delivers the returned nonce rather than the counter value at capture time.

// File: rtl/mine_ctrl.sv
module mine_ctrl #(
  parameter logic [31:0] BASE = 32'h3000_0000,
  parameter int HASH_W = 256
) (
  input  logic              wb_clk,
  input  logic              wb_rst,
  input  logic              wbs_cyc,
  input  logic              wbs_stb,
  input  logic              wbs_we,
  input  logic [3:0]        wbs_sel,
  input  logic [31:0]       wbs_adr,
  input  logic [31:0]       wbs_dat_i,
  output logic              wbs_ack,
  output logic [31:0]       wbs_dat_o,
  input  logic              m_clk,
  input  logic              m_rst,
  output logic [63:0]       cand_nonce,
  input  logic              hash_vld,
  input  logic [63:0]       hash_nonce,
  input  logic [HASH_W-1:0] hash_val,
  output logic [7:0]        pad_first,
  output logic [7:0]        pad_last
);
  localparam int NDW = HASH_W / 32;
  localparam int NREG = 4 + NDW;
  localparam int AW = $clog2(NREG);
  localparam logic [31:0] CTRL_MASK = 32'hFFFF_0007;

  function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n, input logic [3:0] s);
    lanes = o;
    for (int b = 0; b < 4; b++)
      if (s[b]) lanes[b*8 +: 8] = n[b*8 +: 8];
  endfunction

  // bus domain
  logic [31:0]       ctrl_r;
  logic [HASH_W-1:0] diff_r;
  logic              cfg_t, ack_t, found_b;
  logic [63:0]       sol_b;
  logic [2:0]        sol_s;
  logic [1:0]        run_s, tst_s;
  logic [31:0]       rd;

  // miner domain
  logic              run_q, test_q, halt_q, found_q, eq_q, sol_t;
  logic              running_r, testing_r;
  logic [HASH_W-1:0] diff_q;
  logic [63:0]       sol_m;
  logic [2:0]        cfg_s;
  logic [1:0]        ack_s;

  wire          in_win   = wbs_adr[31:AW+2] == BASE[31:AW+2];
  wire [AW-1:0] widx     = wbs_adr[AW+1:2];
  wire          req      = wbs_cyc && wbs_stb && !wbs_ack;
  wire          wr       = req && wbs_we && in_win;
  wire [31:0]   ctrl_nx  = lanes(ctrl_r, wbs_dat_i, wbs_sel) & CTRL_MASK;
  wire          unused_a = ^wbs_adr[1:0];

  always_comb begin
    rd = '0;
    if (in_win) begin
      if (widx == AW'(0)) rd = sol_b[31:0];
      if (widx == AW'(1)) rd = sol_b[63:32];
      if (widx == AW'(2)) rd = {29'd0, tst_s[1], run_s[1], found_b};
      if (widx == AW'(3)) rd = ctrl_r;
      for (int i = 0; i < NDW; i++)
        if (widx == AW'(4 + i)) rd = diff_r[32*i +: 32];
    end
  end

  always_ff @(posedge wb_clk) begin
    if (wb_rst) begin
      wbs_ack   <= 1'b0;
      wbs_dat_o <= '0;
      ctrl_r    <= '0;
      diff_r    <= '0;
      cfg_t     <= 1'b0;
      ack_t     <= 1'b0;
      found_b   <= 1'b0;
      sol_b     <= '0;
      sol_s     <= '0;
      run_s     <= '0;
      tst_s     <= '0;
    end else begin
      wbs_ack <= req;
      if (req && !wbs_we) wbs_dat_o <= rd;
      if (wr && widx == AW'(3)) begin
        ctrl_r <= ctrl_nx;
        cfg_t  <= ~cfg_t;
        if (!ctrl_nx[0]) found_b <= 1'b0;
      end
      for (int i = 0; i < NDW; i++)
        if (wr && widx == AW'(4 + i)) begin
          diff_r[32*i +: 32] <= lanes(diff_r[32*i +: 32], wbs_dat_i, wbs_sel);
          cfg_t <= ~cfg_t;
        end
      sol_s <= {sol_s[1:0], sol_t};
      if (sol_s[2] ^ sol_s[1]) begin
        sol_b   <= sol_m;
        found_b <= 1'b1;
        ack_t   <= ~ack_t;
      end
      run_s <= {run_s[0], running_r};
      tst_s <= {tst_s[0], testing_r};
    end
  end

  wire load = cfg_s[2] ^ cfg_s[1];
  wire eq   = hash_val == diff_q;
  wire le   = hash_val <= diff_q;
  wire hit  = run_q && !halt_q && !found_q && hash_vld && (test_q ? eq : le) && (sol_t == ack_s[1]);

  always_ff @(posedge m_clk) begin
    if (m_rst) begin
      cfg_s      <= '0;
      ack_s      <= '0;
      run_q      <= 1'b0;
      test_q     <= 1'b0;
      halt_q     <= 1'b0;
      diff_q     <= '0;
      pad_first  <= '0;
      pad_last   <= '0;
      cand_nonce <= '0;
      found_q    <= 1'b0;
      eq_q       <= 1'b0;
      sol_m      <= '0;
      sol_t      <= 1'b0;
      running_r  <= 1'b0;
      testing_r  <= 1'b0;
    end else begin
      cfg_s <= {cfg_s[1:0], cfg_t};
      ack_s <= {ack_s[0], ack_t};
      if (load) begin
        run_q     <= ctrl_r[0];
        test_q    <= ctrl_r[1];
        halt_q    <= ctrl_r[2];
        pad_last  <= ctrl_r[23:16];
        pad_first <= ctrl_r[31:24];
        diff_q    <= diff_r;
      end
      if (!run_q) begin
        cand_nonce <= '0;
        found_q    <= 1'b0;
        eq_q       <= 1'b0;
      end else begin
        if (hash_vld) eq_q <= eq;
        if (hit) begin
          found_q    <= 1'b1;
          cand_nonce <= hash_nonce;
          sol_m      <= hash_nonce;
          sol_t      <= ~sol_t;
        end else if (!halt_q && !found_q) begin
          cand_nonce <= cand_nonce + 64'd1;
        end
      end
      running_r <= run_q && !halt_q && !found_q;
      testing_r <= test_q && eq_q;
    end
  end
endmodule

// File: rtl/mine_ctrl_chk.sv
module mine_ctrl_chk (
  input logic        wb_clk,
  input logic        wb_rst,
  input logic        m_clk,
  input logic        m_rst,
  input logic        wbs_ack,
  input logic [63:0] cand_nonce,
  input logic        run_q,
  input logic        halt_q,
  input logic        found_q,
  input logic        hit,
  input logic        found_b,
  input logic [63:0] sol_b
);
  assert_ack_pulse_R2: assert property (@(posedge wb_clk) disable iff (wb_rst)
    wbs_ack |=> !wbs_ack);

  assert_nonce_step_R4: assert property (@(posedge m_clk) disable iff (m_rst)
    (run_q && !halt_q && !found_q && !hit) |=> cand_nonce == $past(cand_nonce) + 64'd1);

  assert_freeze_R5: assert property (@(posedge m_clk) disable iff (m_rst)
    (run_q && found_q) |=> cand_nonce == $past(cand_nonce));

  assert_sol_stable_R5: assert property (@(posedge wb_clk) disable iff (wb_rst)
    (found_b && $past(found_b)) |-> $stable(sol_b));

  assert_halt_hold_R8: assert property (@(posedge m_clk) disable iff (m_rst)
    (run_q && halt_q) |=> cand_nonce == $past(cand_nonce) && !$rose(found_q));

  assert_rearm_R9: assert property (@(posedge m_clk) disable iff (m_rst)
    !run_q |=> cand_nonce == 64'd0 && !found_q);
endmodule

bind mine_ctrl mine_ctrl_chk u_chk (
  .wb_clk(wb_clk), .wb_rst(wb_rst), .m_clk(m_clk), .m_rst(m_rst),
  .wbs_ack(wbs_ack), .cand_nonce(cand_nonce), .run_q(run_q), .halt_q(halt_q),
  .found_q(found_q), .hit(hit), .found_b(found_b), .sol_b(sol_b)
);

// File: tb/sim_mine_ctrl.sv
`timescale 1ns/1ps
module sim_mine_ctrl;
  localparam int HW = 256;
  localparam logic [31:0] B = 32'h3000_0000;

  logic wb_clk = 0, m_clk = 0, wb_rst = 1, m_rst = 1;
  logic wbs_cyc = 0, wbs_stb = 0, wbs_we = 0;
  logic [3:0] wbs_sel = 4'hF;
  logic [31:0] wbs_adr = '0, wbs_dat_i = '0;
  logic wbs_ack;
  logic [31:0] wbs_dat_o;
  logic [63:0] cand_nonce;
  logic hash_vld = 0;
  logic [63:0] hash_nonce = '0;
  logic [HW-1:0] hash_val = '0;
  logic [7:0] pad_first, pad_last;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 wb_clk = ~wb_clk;
  always #3.5 m_clk = ~m_clk;

  mine_ctrl #(.BASE(B), .HASH_W(HW)) u0 (.*);

  task automatic note(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge wb_clk)
    if (wbs_ack && wbs_cyc && !wbs_we) begin
      if (exp_q.size() == 0) note(1'b0, "R2 unexpected read", {32'd0, wbs_dat_o}, 64'd0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        note(wbs_dat_o == e, t, {32'd0, wbs_dat_o}, {32'd0, e});
      end
    end

  task automatic bus(input logic [31:0] a, input logic [31:0] d, input logic w, input logic [3:0] s);
    @(negedge wb_clk);
    wbs_cyc = 1; wbs_stb = 1; wbs_we = w; wbs_adr = a; wbs_dat_i = d; wbs_sel = s;
    do @(negedge wb_clk); while (!wbs_ack);
    #1 wbs_cyc = 0; wbs_stb = 0; wbs_we = 0; wbs_sel = 4'hF;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    bus(a, d, 1'b1, 4'hF);
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus(a, 32'd0, 1'b0, 4'hF);
  endtask

  task automatic settle();
    repeat (12) @(negedge m_clk);
  endtask

  task automatic hash(input logic [63:0] n, input logic [HW-1:0] v);
    @(negedge m_clk);
    hash_vld = 1; hash_nonce = n; hash_val = v;
    @(negedge m_clk);
    hash_vld = 0;
  endtask

  task automatic step_chk(input string t);
    logic [63:0] n1;
    @(negedge m_clk); n1 = cand_nonce;
    @(negedge m_clk); note(cand_nonce == n1 + 64'd1, t, cand_nonce, n1 + 64'd1);
  endtask

  task automatic hold_chk(input logic [63:0] v, input string t);
    @(negedge m_clk); note(cand_nonce == v, t, cand_nonce, v);
    @(negedge m_clk); note(cand_nonce == v, t, cand_nonce, v);
  endtask

  localparam logic [63:0] WIN = 64'h0000_00AB_CDEF_0123;

  initial begin
    repeat (4) @(negedge wb_clk);
    wb_rst = 0; m_rst = 0;
    settle();
    // R1
    note(cand_nonce == 0, "R1 nonce", cand_nonce, 0);
    rd(B + 0, 0, "R1 sol lo");
    rd(B + 4, 0, "R1 sol hi");
    rd(B + 8, 0, "R1 status");
    rd(B + 12, 0, "R1 control");
    // R2
    wr(B + 16, 32'h0000_1000);
    rd(B + 16, 32'h0000_1000, "R2 target word0");
    rd(B + 44, 0, "R2 target word7");
    wr(B + 12, 32'h0680_FFF8);
    rd(B + 12, 32'h0680_0000, "R2 control mask");
    bus(B + 12, 32'hAA00_00FF, 1'b1, 4'b1000);
    rd(B + 12, 32'hAA80_0000, "R2 byte lane");
    settle();
    note(pad_first == 8'hAA, "R10 pad_first", {56'd0, pad_first}, 64'hAA);
    note(pad_last == 8'h80, "R10 pad_last", {56'd0, pad_last}, 64'h80);
    // R3
    wr(B + 0, 32'hDEAD_BEEF);
    wr(B + 8, 32'h7);
    rd(B + 0, 0, "R3 sol lo write ignored");
    rd(B + 8, 0, "R3 status write ignored");
    wr(32'h4000_000C, 32'h7);
    rd(32'h4000_000C, 0, "R3 outside read");
    rd(B + 12, 32'hAA80_0000, "R3 outside write ignored");
    // R4
    wr(B + 12, 32'h0680_0001);
    settle();
    step_chk("R4 increment");
    step_chk("R4 increment again");
    rd(B + 8, 32'h2, "R4 running");
    // R6
    hash(64'd5, HW'(32'h1001));
    settle();
    rd(B + 8, 32'h2, "R6 above target ignored");
    step_chk("R6 still counting");
    // R5
    hash(WIN, HW'(32'h1000));
    hold_chk(WIN, "R5 frozen");
    settle();
    hold_chk(WIN, "R5 frozen later");
    rd(B + 8, 32'h1, "R5 found");
    rd(B + 0, WIN[31:0], "R5 sol lo");
    rd(B + 4, WIN[63:32], "R5 sol hi");
    // R9
    wr(B + 12, 32'h0680_0000);
    settle();
    note(cand_nonce == 0, "R9 nonce cleared", cand_nonce, 0);
    rd(B + 8, 0, "R9 found cleared");
    // R7
    wr(B + 12, 32'h0680_0003);
    settle();
    hash(64'd7, HW'(32'h0FFF));
    settle();
    rd(B + 8, 32'h2, "R7 below target refused");
    step_chk("R7 still counting");
    hash(64'd9, HW'(32'h1000));
    settle();
    rd(B + 8, 32'h5, "R7 exact found testing");
    rd(B + 0, 32'd9, "R7 sol lo");
    note(cand_nonce == 9, "R7 frozen", cand_nonce, 9);
    // R8
    wr(B + 12, 32'h0680_0000);
    settle();
    wr(B + 12, 32'h0680_0005);
    settle();
    hold_chk(0, "R8 halt holds");
    hash(64'd3, HW'(32'h1000));
    settle();
    hold_chk(0, "R8 hit ignored");
    rd(B + 8, 0, "R8 status");
    rd(B + 0, 32'd9, "R8 sol unchanged");
    wr(B + 12, 32'h0680_0001);
    settle();
    step_chk("R8 resume");
    rd(B + 8, 32'h2, "R9 rearmed running");
    wait (exp_q.size() == 0);
    repeat (4) @(negedge wb_clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wb_clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule